// File: doc/BRIEF.md
# Card Clock Divider with Update Handshake

This block derives the clock sent to a memory card from the source clock it runs on. A programmable even divider sets the card clock frequency. An enable gate turns the clock on and off, and an optional low-power mode parks the clock while the card reports idle. Software writes the divider and enable values into holding registers. Those writes have no effect on the clock by themselves.

The held values move into the working registers only when software writes a command that asks for a clock update. The command's start bit reads back as 1 while the update is pending and drops to 0 once the clock logic has taken the new values, so software can poll it. An update command may also ask to wait for the previous data transfer. Such a command stays pending while the card signals busy. The working values change only while the card clock is low, so the output never carries a shortened high pulse.

Top module: `cclk_divider`

## Requirements
- R1: After reset, `card_clk` is low, `cmd_start` is 0, the gate is off and the active divider is 0.
- R2: With an active divider N greater than 0 and the clock running, `card_clk` is high for N source cycles and low for N source cycles, so its period is 2*N.
- R3: With an active divider of 0 and the clock running, `card_clk` follows the source clock.
- R4: The write port selects registers with `wr_addr`. Address 0 is the divider (data bits DIV_W-1:0). Address 1 is the source select. Address 2 is the enable register: bit 0 is the gate and bit 16 is low power. Address 3 is the command. Writes to addresses 0 and 2 change nothing at the output until a command write with both bit 31 (start) and bit 21 (update clock) set has been taken.
- R5: A command write that lacks bit 31 or bit 21 leaves `cmd_start` at 0 and the clock unchanged. A command written while an update is pending is ignored.
- R6: `cmd_start` reads 1 from the cycle after an accepted update command until the update is taken. If the command had bit 13 (wait for previous data) set, the update is not taken while `card_busy` is 1.
- R7: The new values are taken only while the card clock is low. When the gate is turned off, the current high half still completes and the clock then stays low.
- R8: With low power set, the clock stops low while `card_idle` is 1, after completing any high half in progress. It resumes when `card_idle` returns to 0.
- R9: Writes to the source select address have no effect, since only one source exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 32 | Write data |
| card_busy | input | 1 | Card is holding its data line busy |
| card_idle | input | 1 | Card is idle, so low power may stop the clock |
| cmd_start | output | 1 | Read-back of the start bit of the update command |
| card_clk | output | 1 | Gated, divided card clock |

## Verification
The assertions check on every cycle that:
- the start bit rises only on a valid update command;
- the start bit stays pending while a waiting command sees a busy card;
- settings are taken only in the low phase;
- the phase toggles only with a nonzero divider;
- a stopped clock stays low.

The bench's scenarios show the rest: the measured periods for several divider values, the bypass at divider 0, and the way the output reacts over time to gating, low power and ignored writes. These are checked against a cycle-level model.

// File: rtl/cclk_divider.sv
module cclk_divider #(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        card_busy,
  input  logic        card_idle,
  output logic        cmd_start,
  output logic        card_clk
);
  localparam logic [1:0] A_DIV = 2'd0;
  localparam logic [1:0] A_ENA = 2'd2;
  localparam logic [1:0] A_CMD = 2'd3;

  logic [DIV_W-1:0] div_sh, div_act, cnt;
  logic ena_sh, lp_sh, ena_act, lp_act;
  logic start_q, wait_q, ph, byp_n;

  wire running  = ena_act & ~(lp_act & card_idle);
  wire apply    = start_q & ~(wait_q & card_busy) & ~ph;
  wire cmd_ok   = wr_en & (wr_addr == A_CMD) & wr_data[31] & wr_data[21];
  wire advance  = (div_act != '0) & (running | ph);
  wire cnt_last = (cnt == div_act - 1'b1);
  wire unused_wr = ^wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_sh <= '0;
      ena_sh <= 1'b0;
      lp_sh  <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == A_DIV) div_sh <= wr_data[DIV_W-1:0];
      if (wr_addr == A_ENA) begin
        ena_sh <= wr_data[0];
        lp_sh  <= wr_data[16];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      start_q <= 1'b0;
      wait_q  <= 1'b0;
    end else if (apply) begin
      start_q <= 1'b0;
    end else if (cmd_ok && !start_q) begin
      start_q <= 1'b1;
      wait_q  <= wr_data[13];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_act <= '0;
      ena_act <= 1'b0;
      lp_act  <= 1'b0;
      cnt     <= '0;
      ph      <= 1'b0;
    end else if (apply) begin
      div_act <= div_sh;
      ena_act <= ena_sh;
      lp_act  <= lp_sh;
      cnt     <= '0;
    end else if (advance) begin
      if (cnt_last) begin
        cnt <= '0;
        ph  <= ~ph;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) byp_n <= 1'b0;
    else        byp_n <= (div_act == '0) & running;

  assign cmd_start = start_q;
  assign card_clk  = byp_n ? clk : ph;
endmodule

// File: rtl/cclk_divider_chk.sv
module cclk_divider_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [31:0]      wr_data,
  input logic             card_busy,
  input logic             start_q,
  input logic             wait_q,
  input logic             ph,
  input logic             running,
  input logic [DIV_W-1:0] div_act
);
  // R4
  start_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_q) |-> $past(wr_en && wr_addr == 2'd3 && wr_data[31] && wr_data[21]));

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start_q) && $past(wait_q) && $past(card_busy)) |-> start_q);

  // R7
  apply_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_q) |-> !$past(ph));

  // R2
  toggle_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != $past(ph)) |-> ($past(div_act) != '0));

  // R8
  stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(running) && !$past(ph)) |-> !ph);
endmodule

bind cclk_divider cclk_divider_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .card_busy(card_busy), .start_q(start_q),
  .wait_q(wait_q), .ph(ph), .running(running), .div_act(div_act)
);

// File: tb/sim_cclk_divider.sv
`timescale 1ns/1ps
module sim_cclk_divider;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, card_busy = 1'b0, card_idle = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic cmd_start, card_clk;

  always #2.5 clk = ~clk;

  cclk_divider u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .card_busy(card_busy), .card_idle(card_idle),
    .cmd_start(cmd_start), .card_clk(card_clk));

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_sdiv, m_sena, m_slp, m_div, m_ena, m_lp, m_cnt, m_start, m_wait, m_ph, m_byp;
  always @(posedge clk) begin
    bit run, app, cmdw;
    if (!rst_n) begin
      m_sdiv = 0; m_sena = 0; m_slp = 0; m_div = 0; m_ena = 0; m_lp = 0;
      m_cnt = 0; m_start = 0; m_wait = 0; m_ph = 0;
    end else begin
      run  = m_ena != 0 && !(m_lp != 0 && card_idle);
      app  = m_start != 0 && !(m_wait != 0 && card_busy) && m_ph == 0;
      cmdw = wr_en && wr_addr == 2'd3 && wr_data[31] && wr_data[21];
      if (app) begin
        m_div = m_sdiv; m_ena = m_sena; m_lp = m_slp; m_cnt = 0; m_start = 0;
      end else begin
        if (m_div != 0 && (run || m_ph != 0)) begin
          m_cnt++;
          if (m_cnt == m_div) begin m_cnt = 0; m_ph = 1 - m_ph; end
        end
        if (cmdw && m_start == 0) begin m_start = 1; m_wait = wr_data[13]; end
      end
      if (wr_en && wr_addr == 2'd0) m_sdiv = wr_data[7:0];
      if (wr_en && wr_addr == 2'd2) begin m_sena = wr_data[0]; m_slp = wr_data[16]; end
      #1;
      // R2 R3 R7 R8: cycle compare
      check(card_clk == ((m_byp != 0) ? 1'b1 : m_ph[0]), "R2/R3/R7 card_clk vs model",
            card_clk, (m_byp != 0) ? 1 : m_ph);
      check(cmd_start == m_start[0], "R6 cmd_start vs model", cmd_start, m_start);
    end
  end
  always @(negedge clk)
    if (!rst_n) m_byp = 0;
    else m_byp = (m_div == 0 && m_ena != 0 && !(m_lp != 0 && card_idle)) ? 1 : 0;

  task automatic step(); @(posedge clk); #2; endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic update(input bit wt);
    wr(2'd3, 32'h8020_0000 | (wt ? 32'h2000 : 32'h0));
  endtask

  task automatic wait_taken(input string req);
    int n = 0;
    while (cmd_start && n < 50) begin step(); n++; end
    check(!cmd_start, req, cmd_start, 0);
  endtask

  task automatic period(output int p);
    int n = 0;
    bit prev = card_clk;
    p = -1;
    while (n < 100 && !(card_clk && !prev)) begin prev = card_clk; step(); n++; end
    n = 0; prev = card_clk;
    while (n < 100) begin
      step(); n++;
      if (card_clk && !prev) begin p = n; break; end
      prev = card_clk;
    end
  endtask

  task automatic count_high(input int cyc, output int h);
    h = 0;
    for (int i = 0; i < cyc; i++) begin step(); if (card_clk) h++; end
  endtask

  initial begin
    int p, h;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    step();
    // R1
    check(card_clk == 0, "R1 card_clk after reset", card_clk, 0);
    check(cmd_start == 0, "R1 cmd_start after reset", cmd_start, 0);

    // R4: settings held until update
    wr(2'd0, 32'd3); wr(2'd2, 32'd1);
    count_high(20, h);
    check(h == 0, "R4 no clock before update", h, 0);
    update(0);
    check(cmd_start == 1, "R6 start reads 1 after command", cmd_start, 1);
    wait_taken("R6 start clears");
    period(p);
    check(p == 6, "R2 period N=3", p, 6);

    // R5
    wr(2'd3, 32'h8000_0000);
    check(cmd_start == 0, "R5 start without update bit", cmd_start, 0);
    wr(2'd3, 32'h0020_0000);
    check(cmd_start == 0, "R5 update bit without start", cmd_start, 0);
    period(p);
    check(p == 6, "R5 period unchanged", p, 6);

    // R9
    wr(2'd1, 32'h5);
    update(0); wait_taken("R9 update taken");
    period(p);
    check(p == 6, "R9 source select no effect", p, 6);

    // R3 bypass
    wr(2'd0, 32'd0); update(0); wait_taken("R3 update taken");
    repeat (2) step();
    count_high(10, h);
    check(h == 10, "R3 bypass high phase", h, 10);
    #1;
    check(card_clk == 0, "R3 bypass low phase", card_clk, 0);
    #1;

    // R6 busy hold with wait bit
    card_busy = 1'b1;
    wr(2'd0, 32'd1); update(1);
    repeat (10) step();
    check(cmd_start == 1, "R6 held while busy", cmd_start, 1);
    card_busy = 1'b0;
    wait_taken("R6 taken after busy");
    period(p);
    check(p == 2, "R2 period N=1", p, 2);

    // R8 low power
    wr(2'd2, 32'h0001_0001); update(0); wait_taken("R8 update taken");
    card_idle = 1'b1;
    repeat (3) step();
    count_high(12, h);
    check(h == 0, "R8 stopped while idle", h, 0);
    card_idle = 1'b0;
    period(p);
    check(p == 2, "R8 resumes", p, 2);

    // R7 gate off finishes high half
    wr(2'd2, 32'd1); wr(2'd0, 32'd4); update(0); wait_taken("R7 update taken");
    period(p);
    check(p == 8, "R2 period N=4", p, 8);
    count_high(8, h);
    check(h == 4, "R7 duty N=4", h, 4);
    wr(2'd2, 32'd0); update(0); wait_taken("R7 gate-off taken");
    repeat (2) step();
    count_high(16, h);
    check(h == 0, "R7 gated off low", h, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule